// File: doc/BRIEF.md
# Four-Channel Cell Transmit Capture

This block sits on the physical-layer side of an 8-bit cell transmit bus that serves several channels. Each channel has its own enable line from the cell-layer device and its own cell-available line back to it. A single start-of-cell strobe is shared by all channels. The block takes one byte per clock from the shared data lines and assigns it to the channel whose enable is high. It assembles 53-byte cells and forwards every accepted byte to a registered write port. Each forwarded byte carries its channel number, a first-byte mark and a last-byte mark, so a downstream per-channel buffer can store it directly.

Flow control has two modes, selected by `flow_mode`.

- **Cell mode** (`flow_mode` = 0): the cell-available line is only advice given before a cell starts. Once the cell-layer device sends a byte with its enable high, the byte is taken.
- **Byte mode** (`flow_mode` = 1): a byte is taken only while that channel's cell-available line is high.

The control bit that drives `flow_mode` resets to cell mode. That bit lives outside this block.

The block also checks each forwarded byte for odd parity. It reports three error conditions: a restart in the middle of a cell, a byte with bad parity, and more than one enable high at once. Each has a flag that stays set until reset.

Top module: `cellcap_top`

## Requirements
- R1: With the default combinational variant, `tx_clav[c]` equals `fifo_room[c]` in the same cycle, for every channel c.
- R2: A byte is taken for channel c when exactly one enable, `tx_en[c]`, is high and `tx_soc` is high. On the clock after that edge, the write port shows `wr_en`=1, `wr_ch`=c, `wr_sop`=1, and `wr_data` equal to the byte.
- R3: After a start byte, the channel counts taken bytes. The 53rd byte is forwarded with `wr_eoc`=1 and `wr_sop`=0, and the channel then returns to idle. A byte taken while the channel is idle and `tx_soc` is low is not forwarded.
- R4: A clock with the channel's enable low forwards nothing. The cell then continues from where it paused: the byte count is kept.
- R5: In cell mode (`flow_mode`=0), a byte with the enable high is taken whatever the value of `fifo_room` for that channel.
- R6: In byte mode (`flow_mode`=1), a byte for channel c is taken only when `fifo_room[c]` is high. A refused byte is neither forwarded nor counted.
- R7: Odd parity is expected over `{tx_data, tx_par}`. A forwarded byte that fails this check sets `par_err[c]`, which stays set until reset. The byte is still forwarded.
- R8: A start byte that arrives while channel c is inside a cell sets `runt_err[c]`, which stays set until reset. The partial cell is abandoned, and a new cell of 53 bytes starts with that byte, which is marked `wr_sop`.
- R9: A clock with more than one enable high forwards nothing, changes no channel's state, and sets `proto_err`, which stays set until reset.
- R10: After reset, `wr_en`, `wr_sop`, `wr_eoc`, `par_err`, `runt_err` and `proto_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flow_mode | input | 1 | 0 = cell-granular flow control, 1 = byte-granular |
| tx_data | input | DATA_W | Shared data byte |
| tx_par | input | 1 | Odd-parity bit for tx_data |
| tx_soc | input | 1 | Shared start-of-cell strobe |
| tx_en | input | NUM_CH | Per-channel enable from the cell-layer device |
| fifo_room | input | NUM_CH | Per-channel buffer has room for a full cell |
| tx_clav | output | NUM_CH | Per-channel cell-available to the cell-layer device |
| wr_en | output | 1 | Write strobe to the per-channel buffers |
| wr_ch | output | CH_W | Channel the write belongs to |
| wr_data | output | DATA_W | Forwarded byte |
| wr_sop | output | 1 | Forwarded byte is the first byte of a cell |
| wr_eoc | output | 1 | Forwarded byte is the last byte of a cell |
| par_err | output | NUM_CH | Sticky parity error, one per channel |
| runt_err | output | NUM_CH | Sticky restart-inside-cell error, one per channel |
| proto_err | output | 1 | Sticky multiple-enable error |

## Verification
The bench builds the block with its default parameters: four channels, 8-bit data, 53-byte cells and a combinational cell-available path. With four channels, the bench can run a cell on one channel while another channel's cell is partly done. It can also raise two enables at once on channels with different state. The full 53-byte length exercises the wrap of the 6-bit counter at its last byte, the restart of a cell from a mid-cell start byte, and byte-mode refusals spread across a whole cell.

// File: rtl/cellcap_pkg.sv
package cellcap_pkg;
   typedef enum logic {
      FLOW_CELL = 1'b0,
      FLOW_BYTE = 1'b1
   } flow_mode_e;

   function automatic int unsigned ch_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/cellcap_select.sv
module cellcap_select #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tx_en,
   input  logic [NUM_CH-1:0] room,
   input  logic              byte_mode,
   output logic              hit,
   output logic [CH_W-1:0]   hit_ch,
   output logic              multi
);
   logic single;

   always_comb begin
      hit_ch = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (tx_en[i]) hit_ch = CH_W'(i);
      end
      multi  = ($countones(tx_en) > 1);
      single = (tx_en != '0) && !multi;
      hit    = single && (!byte_mode || room[hit_ch]);
   end

   // R9: an accepted byte always comes from exactly one enable
   assert_single_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $onehot(tx_en));
endmodule

// File: rtl/cellcap_chan_track.sv
module cellcap_chan_track #(
   parameter int CELL_BYTES = 53
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic soc,
   input  logic bad_par,
   output logic wr,
   output logic sop,
   output logic eoc,
   output logic runt_err,
   output logic par_err
);
   localparam int CNT_W = $clog2(CELL_BYTES);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELL_BYTES - 1);

   logic             in_cell;
   logic [CNT_W-1:0] cnt;

   always_comb begin
      sop = take && soc;
      wr  = take && (soc || in_cell);
      eoc = take && !soc && in_cell && (cnt == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_cell  <= 1'b0;
         cnt      <= '0;
         runt_err <= 1'b0;
         par_err  <= 1'b0;
      end else begin
         if (take) begin
            if (soc) begin
               if (in_cell) runt_err <= 1'b1;
               in_cell <= 1'b1;
               cnt     <= CNT_W'(1);
            end else if (in_cell) begin
               if (cnt == LAST_IDX) begin
                  in_cell <= 1'b0;
                  cnt     <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
         end
         if (wr && bad_par) par_err <= 1'b1;
      end
   end

   // R7: once raised, the parity flag never drops
   assert_par_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      par_err |=> par_err);
   // R8: a start byte inside a cell raises the restart flag
   assert_runt_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (take && soc && in_cell) |=> runt_err);
   // R3: the count never passes the last byte index
   assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST_IDX);
endmodule

// File: rtl/cellcap_top.sv
module cellcap_top
   import cellcap_pkg::*;
#(
   parameter int NUM_CH     = 4,
   parameter int DATA_W     = 8,
   parameter int CELL_BYTES = 53,
   parameter bit REG_CLAV   = 1'b0,
   parameter int CH_W       = ch_bits(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flow_mode,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_par,
   input  logic              tx_soc,
   input  logic [NUM_CH-1:0] tx_en,
   input  logic [NUM_CH-1:0] fifo_room,
   output logic [NUM_CH-1:0] tx_clav,
   output logic              wr_en,
   output logic [CH_W-1:0]   wr_ch,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_sop,
   output logic              wr_eoc,
   output logic [NUM_CH-1:0] par_err,
   output logic [NUM_CH-1:0] runt_err,
   output logic              proto_err
);
   if (NUM_CH < 2) begin : g_bad_ch
      $error("cellcap_top: NUM_CH must be at least 2");
   end
   if (CELL_BYTES < 2) begin : g_bad_len
      $error("cellcap_top: CELL_BYTES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("cellcap_top: DATA_W must be positive");
   end

   logic              byte_mode;
   logic              hit;
   logic              multi;
   logic [CH_W-1:0]   hit_ch;
   logic              bad_par;
   logic [NUM_CH-1:0] take_v, wr_v, sop_v, eoc_v;

   assign byte_mode = (flow_mode_e'(flow_mode) == FLOW_BYTE);
   assign bad_par   = ~(^{tx_data, tx_par});

   if (REG_CLAV) begin : g_clav_reg
      always_ff @(posedge clk) begin
         if (!rst_n) tx_clav <= '0;
         else        tx_clav <= fifo_room;
      end
   end else begin : g_clav_comb
      assign tx_clav = fifo_room;
   end

   cellcap_select #(.NUM_CH(NUM_CH), .CH_W(CH_W)) sel_i (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .room(fifo_room),
      .byte_mode(byte_mode), .hit(hit), .hit_ch(hit_ch), .multi(multi)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      assign take_v[c] = hit && (hit_ch == CH_W'(c));
      cellcap_chan_track #(.CELL_BYTES(CELL_BYTES)) trk_i (
         .clk(clk), .rst_n(rst_n), .take(take_v[c]), .soc(tx_soc),
         .bad_par(bad_par), .wr(wr_v[c]), .sop(sop_v[c]), .eoc(eoc_v[c]),
         .runt_err(runt_err[c]), .par_err(par_err[c])
      );

      // R6: in byte mode a channel without room gets no write
      assert_byte_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (byte_mode && tx_en[c] && !fifo_room[c]) |=> !(wr_en && wr_ch == CH_W'(c)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en     <= 1'b0;
         wr_ch     <= '0;
         wr_data   <= '0;
         wr_sop    <= 1'b0;
         wr_eoc    <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         wr_en   <= |wr_v;
         wr_ch   <= hit_ch;
         wr_data <= tx_data;
         wr_sop  <= |sop_v;
         wr_eoc  <= |eoc_v;
         if (multi) proto_err <= 1'b1;
      end
   end

   // R9: several enables at once give no write and raise the flag
   assert_multi_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(tx_en) > 1) |=> (!wr_en && proto_err));
   // R3: a last-byte mark rides only on a real write and never with a first-byte mark
   assert_eoc_framing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_eoc |-> (wr_en && !wr_sop));
   // R2: a first-byte mark rides only on a real write
   assert_sop_framing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sop |-> wr_en);
endmodule

// File: tb/cellcap_tb.sv
module cellcap_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int CELL = 53;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       flow_mode = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_par = 1'b1;
   logic       tx_soc = 1'b0;
   logic [3:0] tx_en = '0;
   logic [3:0] fifo_room = '0;
   logic [3:0] tx_clav;
   logic       wr_en, wr_sop, wr_eoc, proto_err;
   logic [1:0] wr_ch;
   logic [7:0] wr_data;
   logic [3:0] par_err, runt_err;

   cellcap_top dut_i (
      .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .tx_data(tx_data),
      .tx_par(tx_par), .tx_soc(tx_soc), .tx_en(tx_en), .fifo_room(fifo_room),
      .tx_clav(tx_clav), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
      .wr_sop(wr_sop), .wr_eoc(wr_eoc), .par_err(par_err),
      .runt_err(runt_err), .proto_err(proto_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct packed {
      logic       v;
      logic [1:0] ch;
      logic [7:0] d;
      logic       sop;
      logic       eoc;
   } exp_t;

   exp_t  q[$];
   int    n_vec = 0;
   int    n_bad = 0;
   string cur_req = "R10";
   bit    done = 1'b0;

   // reference state built from the requirements
   bit         m_in[NCH];
   int         m_cnt[NCH];
   logic [3:0] m_par = '0;
   logic [3:0] m_runt = '0;
   logic       m_proto = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // one bus clock of stimulus; pushes the expected write-port result
   task automatic cyc(input logic [3:0] en, input logic [7:0] d, input logic soc,
                      input logic bad, input logic [3:0] room);
      exp_t e;
      int   c;
      @(negedge clk);
      tx_en = en; tx_data = d; tx_soc = soc; fifo_room = room;
      tx_par = (~^d) ^ bad;
      e = '0;
      if ($countones(en) > 1) begin
         m_proto = 1'b1;
      end else if (en != 0) begin
         c = 0;
         for (int i = 0; i < NCH; i++) if (en[i]) c = i;
         if (!flow_mode || room[c]) begin
            if (soc) begin
               if (m_in[c]) m_runt[c] = 1'b1;
               m_in[c] = 1; m_cnt[c] = 1;
               e.v = 1; e.sop = 1;
            end else if (m_in[c]) begin
               e.v = 1;
               e.eoc = (m_cnt[c] == CELL - 1);
               m_cnt[c]++;
               if (e.eoc) begin m_in[c] = 0; m_cnt[c] = 0; end
            end
            if (e.v) begin
               e.ch = 2'(c); e.d = d;
               if (bad) m_par[c] = 1'b1;
            end
         end
      end
      q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(4'b0000, 8'h00, 1'b0, 1'b0, fifo_room);
   endtask

   task automatic send_cell(input int ch, input int seed, input int pause_at,
                            input logic [3:0] room);
      for (int k = 0; k < CELL; k++) begin
         if (k == pause_at) idle(3);
         cyc(4'(1 << ch), 8'((seed + k * 7) & 8'hff), (k == 0), 1'b0, room);
      end
   endtask

   task automatic chk_flags(input string req);
      @(negedge clk);
      #1;
      chk(par_err == m_par, req, "par_err", 16'(par_err), 16'(m_par));
      chk(runt_err == m_runt, req, "runt_err", 16'(runt_err), 16'(m_runt));
      chk(proto_err == m_proto, req, "proto_err", 16'(proto_err), 16'(m_proto));
   endtask

   // monitor: compare the write port against the scoreboard after each edge
   always @(posedge clk) begin
      exp_t e;
      #2;
      if (rst_n && q.size() > 0) begin
         e = q.pop_front();
         chk(wr_en == e.v, cur_req, "wr_en", 16'(wr_en), 16'(e.v));
         if (e.v && wr_en) begin
            chk({wr_ch, wr_data, wr_sop, wr_eoc} == {e.ch, e.d, e.sop, e.eoc},
                cur_req, "ch/data/sop/eoc",
                16'({wr_ch, wr_data, wr_sop, wr_eoc}),
                16'({e.ch, e.d, e.sop, e.eoc}));
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NCH; i++) begin m_in[i] = 0; m_cnt[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10: reset state
      chk(!wr_en && !wr_sop && !wr_eoc, "R10", "write port idle",
          16'({wr_en, wr_sop, wr_eoc}), 16'h0);
      chk(par_err == 0 && runt_err == 0 && !proto_err, "R10", "flags clear",
          16'({par_err, runt_err, proto_err}), 16'h0);

      // R1: cell-available follows room combinationally
      cur_req = "R1";
      foreach (fifo_room[i]) begin end
      for (int p = 0; p < 4; p++) begin
         @(negedge clk);
         fifo_room = 4'(4'b1010 >> p) | 4'(p);
         #1;
         chk(tx_clav == fifo_room, "R1", "tx_clav", 16'(tx_clav), 16'(fifo_room));
      end

      // R2 / R3: full cell on channel 0, then a stray byte dropped
      cur_req = "R2_R3";
      send_cell(0, 8'h11, -1, 4'b1111);
      cur_req = "R3";
      cyc(4'b0001, 8'hA5, 1'b0, 1'b0, 4'b1111);
      idle(2);

      // R4: pauses inside a cell on channel 2
      cur_req = "R4";
      send_cell(2, 8'h40, 17, 4'b1111);
      idle(1);

      // R5: cell mode ignores room
      cur_req = "R5";
      send_cell(1, 8'h83, -1, 4'b0000);
      idle(1);

      // R7: bad parity mid-cell on channel 3 still forwarded
      cur_req = "R7";
      for (int k = 0; k < CELL; k++)
         cyc(4'b1000, 8'((k * 13) & 8'hff), (k == 0), (k == 5), 4'b1111);
      chk_flags("R7");

      // R8: restart inside a cell on channel 0
      cur_req = "R8";
      for (int k = 0; k < 20; k++)
         cyc(4'b0001, 8'(k + 1), (k == 0), 1'b0, 4'b1111);
      send_cell(0, 8'hC0, -1, 4'b1111);
      chk_flags("R8");

      // R9: two enables at once, with channel 1 mid-cell
      cur_req = "R9";
      for (int k = 0; k < 10; k++)
         cyc(4'b0010, 8'(k + 8'h20), (k == 0), 1'b0, 4'b1111);
      cyc(4'b0011, 8'hEE, 1'b1, 1'b0, 4'b1111);
      for (int k = 10; k < CELL; k++)
         cyc(4'b0010, 8'(k + 8'h20), 1'b0, 1'b0, 4'b1111);
      chk_flags("R9");

      // R6: byte mode, room toggling on channel 3
      cur_req = "R6";
      @(negedge clk);
      flow_mode = 1'b1;
      begin
         int k = 0;
         int t = 0;
         while (k < CELL) begin
            logic r;
            r = ((t % 3) != 1);
            cyc(4'b1000, 8'((k * 3 + 1) & 8'hff), (k == 0), 1'b0, {r, 3'b111});
            if (r) k++;
            t++;
         end
      end
      idle(2);
      chk_flags("R6");
      chk(q.size() == 0, "R6", "scoreboard drained", 16'(q.size()), 16'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule